// File: doc/BRIEF.md
# Stop-Mode Power and Wake Controller

This block sequences the deepest power-saving state of a small processor. Software asks for stop with a one-cycle request. The block then withdraws the CPU run enable, so execution halts while processor and memory state are kept. While stopped, the block watches for a reason to wake. The wake sources are external interrupt lines, the power-fail comparators when the monitor is kept on, and a wake-up counter clocked by a slow 8 kHz tick. Software sets that counter's interval in ticks of 125 µs.

A power-fail-disable bit chooses whether the supply monitor stays powered during stop. On every exit the monitor is switched back on first. The block then waits two slow ticks for the comparators to settle and samples them before it lets the CPU run again. A warning level at that point latches a sticky interrupt flag. A reset level holds the CPU in reset. A power-on-reset level forces a reset request in every state, even while the monitor is off.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, run_o=1, mon_en_o=1, pf_flag_o=0 and rst_req_o=0. The power-fail-disable bit resets to 1, so a stop entered without writing it shows mon_en_o=0.
- R2: A stop_req_i pulse while no wake source is active (no ext_irq_i bit, pfw_i, pfr_i or por_i high) moves the block to stop on that edge: run_o=0 from the next cycle.
- R3: A stop_req_i pulse while any ext_irq_i bit, pfw_i or pfr_i is high is ignored, and run_o stays 1.
- R4: mon_en_o equals the inverse of the power-fail-disable bit while stopped, and is 1 in every other state.
- R5: With the disable bit at 1, pfw_i and pfr_i during stop neither wake the block, raise rst_req_o nor set the flag. With the bit at 0, either of them wakes the block.
- R6: Any ext_irq_i bit high during stop starts the exit sequence on the next edge.
- R7: With interval_i=N, where N is not 0, the exit sequence starts on the Nth tick_i after stop entry. With interval_i=0 the timer never wakes the block.
- R8: During the exit sequence mon_en_o=1 and run_o=0. run_o returns to 1 on the edge of the second tick_i of that sequence, unless a reset is due.
- R9: pf_flag_o is set by pfw_i high in run, or by pfw_i high on the tick that ends the exit sequence. It stays set until a flag_clr_i pulse. A set in the same cycle wins over the clear.
- R10: pfr_i high in run, or on the tick that ends the exit sequence, gives rst_req_o=1 and run_o=0 from the next cycle. This holds until pfr_i and por_i are both low, after which run_o=1.
- R11: por_i high in any state gives rst_req_o=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 8 kHz slow-clock period |
| stop_req_i | input | 1 | Software stop request pulse |
| pfd_we_i | input | 1 | Write strobe for the power-fail-disable bit |
| pfd_wd_i | input | 1 | Value written to the power-fail-disable bit |
| interval_i | input | IVL_W | Wake-up interval in ticks, 0 = timer off |
| ext_irq_i | input | N_IRQ | External interrupt lines |
| pfw_i | input | 1 | Warning-threshold comparator output |
| pfr_i | input | 1 | Reset-threshold comparator output |
| por_i | input | 1 | Power-on-reset level flag |
| flag_clr_i | input | 1 | One-cycle clear of the power-fail flag |
| run_o | output | 1 | CPU run enable |
| mon_en_o | output | 1 | Supply monitor enable |
| pf_flag_o | output | 1 | Sticky power-fail warning flag |
| rst_req_o | output | 1 | Reset request to the CPU |

## Verification
A vector table sweeps several wake intervals with the monitor both kept on and shut off in stop. Each entry separates off-by-one errors in the wake counter from errors in the two-tick settle wait, and shows whether the monitor gating follows the disable bit. Directed sequences then present each wake source on its own: an interrupt, warning and reset levels with the monitor off and on, and a power-on-reset level. These tell apart the monitor-gated sources from those that are always honoured, and a flag latched at exit from a reset held at exit. Further cases cover a stop request that collides with a live wake source, a zero interval, and a clear that arrives together with a set.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RESET  = 2'd3
  } swc_state_e;
endpackage

// File: rtl/swc_rst_sync.sv
module swc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/swc_tick_counter.sv
// Counts slow ticks while enabled and flags the tick on which the count
// reaches the programmed limit. A limit of zero never matches when
// ZERO_OFF is set.
module swc_tick_counter #(
  parameter int W        = 16,
  parameter bit ZERO_OFF = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         limit_ok;

  generate
    if (ZERO_OFF) begin : g_zero_off
      assign limit_ok = (limit_i != '0);
    end else begin : g_zero_on
      assign limit_ok = 1'b1;
    end
  endgenerate

  assign hit_o = en_i & tick_i & limit_ok & (cnt_q == (limit_i - W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)              cnt_d = '0;
    else if (en_i & tick_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/swc_pf_flag.sv
module swc_pf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int N_IRQ        = 4,
  parameter int IVL_W        = 16,
  parameter int SETTLE_TICKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_req_i,
  input  logic             pfd_we_i,
  input  logic             pfd_wd_i,
  input  logic [IVL_W-1:0] interval_i,
  input  logic [N_IRQ-1:0] ext_irq_i,
  input  logic             pfw_i,
  input  logic             pfr_i,
  input  logic             por_i,
  input  logic             flag_clr_i,
  output logic             run_o,
  output logic             mon_en_o,
  output logic             pf_flag_o,
  output logic             rst_req_o
);
  localparam int SET_W = $clog2(SETTLE_TICKS + 1);

  logic       rst_n_s;
  logic       pfd_q;
  swc_state_e state_q, state_d;
  logic       irq_any, live_wake, stop_wake;
  logic       timer_hit, settle_done;
  logic       enter_stop, enter_settle;
  logic       flag_set;

  swc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  // Power-fail-disable bit, defaults to "monitor off in stop".
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)      pfd_q <= 1'b1;
    else if (pfd_we_i) pfd_q <= pfd_wd_i;
  end

  assign irq_any   = |ext_irq_i;
  assign live_wake = irq_any | pfw_i | pfr_i;
  assign mon_en_o  = !((state_q == ST_STOP) && pfd_q);
  assign stop_wake = irq_any | timer_hit | (mon_en_o & (pfw_i | pfr_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (por_i | pfr_i)                   state_d = ST_RESET;
        else if (stop_req_i & !live_wake)    state_d = ST_STOP;
      end
      ST_STOP: begin
        if (por_i)          state_d = ST_RESET;
        else if (stop_wake) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (por_i)            state_d = ST_RESET;
        else if (settle_done) state_d = pfr_i ? ST_RESET : ST_RUN;
      end
      ST_RESET: begin
        if (!por_i & !pfr_i) state_d = ST_RUN;
      end
      default: state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_RUN;
    else          state_q <= state_d;
  end

  assign enter_stop   = (state_q != ST_STOP)   && (state_d == ST_STOP);
  assign enter_settle = (state_q != ST_SETTLE) && (state_d == ST_SETTLE);

  swc_tick_counter #(.W(IVL_W), .ZERO_OFF(1'b1)) u_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .clr_i   (enter_stop),
    .en_i    (state_q == ST_STOP),
    .tick_i  (tick_i),
    .limit_i (interval_i),
    .hit_o   (timer_hit)
  );

  swc_tick_counter #(.W(SET_W), .ZERO_OFF(1'b0)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .clr_i   (enter_settle),
    .en_i    (state_q == ST_SETTLE),
    .tick_i  (tick_i),
    .limit_i (SET_W'(SETTLE_TICKS)),
    .hit_o   (settle_done)
  );

  assign flag_set = pfw_i & ((state_q == ST_RUN) |
                             ((state_q == ST_SETTLE) & settle_done));

  swc_pf_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .flag_o (pf_flag_o)
  );

  assign run_o     = (state_q == ST_RUN);
  assign rst_req_o = (state_q == ST_RESET);
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int N_IRQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             stop_req_i,
  input logic             pfd_we_i,
  input logic [N_IRQ-1:0] ext_irq_i,
  input logic             pfw_i,
  input logic             pfr_i,
  input logic             por_i,
  input logic             flag_clr_i,
  input logic             run_o,
  input logic             mon_en_o,
  input logic             pf_flag_o,
  input logic             rst_req_o
);
  // R10: reset request and run enable never together
  assert_rst_excl_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !run_o);

  // R4: monitor is on whenever the CPU runs
  assert_mon_in_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> mon_en_o);

  // R11: power-on-reset level always leads to a reset request
  assert_por_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i && (run_o || rst_req_o || mon_en_o || !mon_en_o)) |=> rst_req_o);

  // R9: flag is sticky without a clear
  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_flag_o && !flag_clr_i) |=> pf_flag_o);

  // R3: stop request ignored while an interrupt is pending
  assert_stop_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && stop_req_i && (|ext_irq_i) && !por_i && !pfr_i) |=> run_o);

  // R2: clean stop request halts the CPU
  assert_stop_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && stop_req_i && !(|ext_irq_i) && !pfw_i && !pfr_i && !por_i)
      |=> (!run_o && !rst_req_o));

  // R5: with the monitor off and no other wake source, stop persists
  assert_quiet_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !mon_en_o && !(|ext_irq_i) && !por_i && !tick_i && !pfd_we_i)
      |=> (!mon_en_o && !rst_req_o));

  // R8: the CPU is released only after the monitor was already on
  assert_mon_before_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(mon_en_o));
endmodule

bind stop_wake_ctrl swc_checker #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .stop_req_i (stop_req_i),
  .pfd_we_i   (pfd_we_i),
  .ext_irq_i  (ext_irq_i),
  .pfw_i      (pfw_i),
  .pfr_i      (pfr_i),
  .por_i      (por_i),
  .flag_clr_i (flag_clr_i),
  .run_o      (run_o),
  .mon_en_o   (mon_en_o),
  .pf_flag_o  (pf_flag_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
  localparam int N_IRQ = 4;
  localparam int IVL_W = 16;
  localparam int NVEC  = 4;
  // {interval, disable bit}
  localparam logic [16:0] VEC [NVEC] = '{
    {16'd1, 1'b1}, {16'd3, 1'b1}, {16'd4, 1'b0}, {16'd2, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, stop_req = 0, pfd_we = 0, pfd_wd = 0;
  logic [IVL_W-1:0] interval = '0;
  logic [N_IRQ-1:0] irq = '0;
  logic pfw = 0, pfr = 0, por = 0, fclr = 0;
  logic run, mon, flag, rreq;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  stop_wake_ctrl #(.N_IRQ(N_IRQ), .IVL_W(IVL_W), .SETTLE_TICKS(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .stop_req_i(stop_req),
    .pfd_we_i(pfd_we), .pfd_wd_i(pfd_wd), .interval_i(interval),
    .ext_irq_i(irq), .pfw_i(pfw), .pfr_i(pfr), .por_i(por),
    .flag_clr_i(fclr), .run_o(run), .mon_en_o(mon), .pf_flag_o(flag),
    .rst_req_o(rreq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick_pulse();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic set_pfd(input logic v);
    pfd_we = 1'b1; pfd_wd = v; cyc(); pfd_we = 1'b0;
  endtask

  task automatic do_stop();
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    // R1 reset state
    chk("R1 run", run, 1'b1);
    chk("R1 mon", mon, 1'b1);
    chk("R1 flag", flag, 1'b0);
    chk("R1 rst_req", rreq, 1'b0);

    // R3: stop with live interrupt is ignored
    irq = 4'b0100; do_stop(); cyc();
    chk("R3 run kept", run, 1'b1);
    irq = '0;

    // R9: warning in run sets flag, clear drops it
    pfw = 1'b1; do_stop();
    chk("R3 stop ignored on warning", run, 1'b1);
    chk("R9 flag set in run", flag, 1'b1);
    pfw = 1'b0; fclr = 1'b1; cyc(); fclr = 1'b0;
    chk("R9 flag cleared", flag, 1'b0);

    // R1/R7/R5: default disable bit, zero interval, comparators ignored
    interval = '0; do_stop();
    chk("R2 stopped", run, 1'b0);
    chk("R1 disable bit default gates monitor", mon, 1'b0);
    repeat (10) tick_pulse();
    chk("R7 zero interval keeps stop", run, 1'b0);
    pfw = 1'b1; pfr = 1'b1;
    repeat (3) tick_pulse();
    chk("R5 no wake with monitor off", mon, 1'b0);
    chk("R5 no reset with monitor off", rreq, 1'b0);
    chk("R5 no flag with monitor off", flag, 1'b0);
    pfr = 1'b0;
    irq = 4'b0001; cyc(); irq = '0;
    chk("R6 irq wake starts exit, monitor on", mon, 1'b1);
    chk("R8 run held during settle", run, 1'b0);
    tick_pulse();
    chk("R8 run held after one tick", run, 1'b0);
    tick_pulse();
    chk("R8 run after second tick", run, 1'b1);
    chk("R9 warning at exit sets flag", flag, 1'b1);
    pfw = 1'b0; fclr = 1'b1; cyc(); fclr = 1'b0;

    // R5/R10: monitor kept on, reset level wakes and holds reset
    set_pfd(1'b0); do_stop();
    chk("R4 monitor on in stop with bit 0", mon, 1'b1);
    pfr = 1'b1; cyc();
    chk("R5 reset level wakes", mon, 1'b1);
    tick_pulse(); tick_pulse();
    chk("R10 reset requested at exit", rreq, 1'b1);
    chk("R10 run held in reset", run, 1'b0);
    pfr = 1'b0; cyc();
    chk("R10 released to run", run, 1'b1);
    chk("R10 reset dropped", rreq, 1'b0);

    // R11: power-on level in stop with monitor off
    set_pfd(1'b1); do_stop();
    por = 1'b1; cyc(); por = 1'b0;
    chk("R11 por gives reset", rreq, 1'b1);
    cyc();
    chk("R11 back to run", run, 1'b1);

    // R10: reset level while running
    pfr = 1'b1; cyc();
    chk("R10 reset from run", rreq, 1'b1);
    pfr = 1'b0; cyc();
    chk("R10 run after release", run, 1'b1);

    // R9: set beats clear
    pfw = 1'b1; fclr = 1'b1; cyc(); fclr = 1'b0; pfw = 1'b0;
    chk("R9 set wins over clear", flag, 1'b1);
    fclr = 1'b1; cyc(); fclr = 1'b0;

    // Vector table: timer wake for several intervals and disable settings
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] ivl;
      logic        dis;
      ivl = VEC[i][16:1];
      dis = VEC[i][0];
      set_pfd(dis);
      interval = ivl;
      do_stop();
      chk("R2 stop entered", run, 1'b0);
      chk("R4 monitor follows bit", mon, !dis);
      for (int t = 0; t < int'(ivl) - 1; t++) tick_pulse();
      chk("R7 still stopped before Nth tick", run, 1'b0);
      chk("R4 monitor still gated", mon, !dis);
      tick_pulse();
      chk("R7 Nth tick starts exit", mon, 1'b1);
      chk("R8 no run at exit start", run, 1'b0);
      tick_pulse();
      chk("R8 no run after one settle tick", run, 1'b0);
      tick_pulse();
      chk("R8 run after settle", run, 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule